// File: doc/BRIEF.md
# Multichannel Serial ADC Readout Sequencer

This block walks a serial-output ADC through a fixed set of analogue channels, one sweep per start request. The ADC clock is made by dividing the board clock by four, so every ADC event lines up with a known board clock edge. For each channel the block drives the multiplexer select and pulses a conversion strobe. It then waits a programmable number of ADC clock periods for settling and conversion. Finally it opens a 16-period serial window and shifts the result in most significant bit first.

Each finished result is presented for one board cycle on a valid/data output, together with the channel it belongs to. A one-cycle done pulse marks the last channel of the sweep. A mode input, captured at start, picks one of two modes. In the sequential mode nothing converts while data moves. In the overlapped mode the next channel converts while the previous result is shifted out. This shortens a sweep, and the two modes can be compared for noise.

Top module: `adc_sweep_seq`

## Requirements
- R1: `adc_sclk` is the board clock divided by 4. Edges are counted from the first edge after reset is released, as k = 1, 2, and so on. After edge k the clock is high when k mod 4 is 0 or 1 and low otherwise. It is high while reset is held.
- R2: The 16 result bits are sampled most significant bit first, one bit on each edge where k mod 4 = 0 while `adc_csn` is low. The ADC must present each bit once `adc_sclk` has risen. The full word appears on `out_data` with `out_valid` high for exactly one board cycle, starting at the edge that takes the 16th bit. That edge is 64 board cycles after the edge that pulled `adc_csn` low.
- R3: A start is accepted at edge A. The first conversion then begins at S0, the first edge after A with k mod 4 = 0. Let W be the settle count. In the sequential mode, conversion of channel n begins at S0 + n·4(W+16), its shift window begins 4W cycles later, and its word is valid 4W+64 cycles after its conversion began.
- R4: In the overlapped mode, let P = max(W,16). The shift of channel n begins at S0 + 4(W + n·P) and its word is valid 64 cycles later. Conversion of channel n+1 begins on the same edge as the shift of channel n. Conversion of channel 0 begins at S0.
- R5: Channels are handled in order 0 to 17. `mux_sel` carries the channel being converted and stays constant while `adc_cnv` is high. `out_chan` carries the 5-bit index of the word on `out_data`.
- R6: `sweep_done` is high for exactly one board cycle, in the same cycle as the valid word of channel 17.
- R7: A start that arrives from the edge that accepted a sweep up to and including the edge that raises `sweep_done` is ignored. It creates no extra conversions or words.
- R8: The mode input and `settle_ticks` are captured on the edge that accepts the start, and later changes to them do not affect the running sweep. A settle value below 2 is treated as 2.
- R9: While reset is held, `out_valid`, `sweep_done` and `adc_cnv` are 0, `adc_csn` is 1 and `mux_sel` is 0.
- R10: `adc_cnv` is high for exactly one ADC period (4 board cycles) at the start of each conversion. `adc_csn` is low exactly during shift windows. Both change only on edges where `adc_sclk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Sweep request, sampled on every edge |
| overlap_en | input | 1 | 1 selects overlapped conversion and shift |
| settle_ticks | input | SET_W | Settle plus conversion wait in ADC clock periods |
| adc_sclk | output | 1 | ADC clock, board clock divided by 4 |
| adc_cnv | output | 1 | Conversion strobe, one ADC period long |
| adc_csn | output | 1 | Serial window enable, active low |
| adc_sdo | input | 1 | Serial data from the ADC |
| mux_sel | output | CH_W | Analogue channel select |
| out_valid | output | 1 | Result word valid for one cycle |
| out_data | output | DATA_W | Result word |
| out_chan | output | CH_W | Channel index of the result |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Every result is due at a board edge number that can be computed in advance. It depends on the edge that accepted the start, rounded up to the next ADC period boundary. To that are added 4W+64 cycles per channel in the sequential mode, or 4P per channel after the first 4W in the overlapped mode. The bench counts edges from reset release and computes these edge numbers for every conversion strobe, every serial window and every word. It then compares all outputs after each edge against that schedule, so a result that arrives one cycle early or late is reported. The scenarios cover both modes, a settle count longer than, equal to and shorter than the shift window, a clamped settle count, inputs changed after acceptance, and a start request made during a sweep.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [1:0] {
        CV_IDLE,
        CV_RUN,
        CV_HOLD
    } cv_state_e;

    localparam int unsigned MIN_SETTLE = 2;

    function automatic int unsigned period_bits(input int unsigned div);
        return (div <= 2) ? 1 : $clog2(div);
    endfunction

endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv import adcseq_pkg::*; #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic sclk
);
    localparam int PW = period_bits(CLK_DIV);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == PW'(CLK_DIV - 1)) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    // last board cycle of an ADC period; sclk high in the first half
    assign tick = (phase == PW'(CLK_DIV - 1));
    assign sclk = (phase < PW'(CLK_DIV / 2));
endmodule

// File: rtl/adcseq_conv.sv
module adcseq_conv import adcseq_pkg::*; #(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             launch,
    input  logic             ack,
    input  logic [SET_W-1:0] wait_ticks,
    output logic             ready,
    output logic             cnv
);
    cv_state_e        state;
    logic [SET_W-1:0] remain;

    // result available on this period boundary, or held from an earlier one
    assign ready = ((state == CV_RUN) && (remain == SET_W'(1))) || (state == CV_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CV_IDLE;
            remain <= '0;
            cnv    <= 1'b0;
        end else if (tick) begin
            if (launch) begin
                state  <= CV_RUN;
                remain <= wait_ticks;
                cnv    <= 1'b1;
            end else begin
                cnv <= 1'b0;
                case (state)
                    CV_RUN: begin
                        if (remain == SET_W'(1)) begin
                            state <= ack ? CV_IDLE : CV_HOLD;
                        end else begin
                            remain <= remain - SET_W'(1);
                        end
                    end
                    CV_HOLD: begin
                        if (ack) state <= CV_IDLE;
                    end
                    default: state <= CV_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/adcseq_shift.sv
module adcseq_shift #(
    parameter int DATA_W = 16,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              launch,
    input  logic [CH_W-1:0]   chan_in,
    input  logic              sdo,
    output logic              csn,
    output logic              free,
    output logic              fin,
    output logic [CH_W-1:0]   cur_chan,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic [CH_W-1:0]   word_chan
);
    localparam int CW = $clog2(DATA_W + 1);

    logic              active;
    logic [CW-1:0]     left;
    logic [DATA_W-1:0] sreg;

    assign fin  = active && tick && (left == CW'(1));
    assign free = !active || fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            left       <= '0;
            sreg       <= '0;
            csn        <= 1'b1;
            cur_chan   <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_chan  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (tick) begin
                if (active) begin
                    sreg <= {sreg[DATA_W-2:0], sdo};
                    left <= left - CW'(1);
                end
                if (fin) begin
                    word_valid <= 1'b1;
                    word_data  <= {sreg[DATA_W-2:0], sdo};
                    word_chan  <= cur_chan;
                    active     <= 1'b0;
                    csn        <= 1'b1;
                end
                if (launch) begin
                    active   <= 1'b1;
                    left     <= CW'(DATA_W);
                    cur_chan <= chan_in;
                    csn      <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq import adcseq_pkg::*; #(
    parameter int N_CH    = 18,
    parameter int DATA_W  = 16,
    parameter int SET_W   = 8,
    parameter int CLK_DIV = 4,
    parameter int CH_W    = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              overlap_en,
    input  logic [SET_W-1:0]  settle_ticks,
    output logic              adc_sclk,
    output logic              adc_cnv,
    output logic              adc_csn,
    input  logic              adc_sdo,
    output logic [CH_W-1:0]   mux_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_chan,
    output logic              sweep_done
);
    localparam logic [CH_W-1:0]  LAST_CH   = CH_W'(N_CH - 1);
    localparam logic [SET_W-1:0] SETTLE_LO = SET_W'(MIN_SETTLE);

    logic             tick;
    logic             armed, running, ov_mode;
    logic [SET_W-1:0] wait_q, settle_eff;
    logic [CH_W-1:0]  conv_ch, shift_ch;
    logic             conv_ready, shift_free, shift_fin;
    logic             accept, first_go, shift_go, conv_next, conv_go, sweep_end;

    adcseq_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .sclk (adc_sclk)
    );

    assign settle_eff = (settle_ticks < SETTLE_LO) ? SETTLE_LO : settle_ticks;
    assign accept     = start && !armed && !running;
    assign first_go   = tick && armed;
    assign shift_go   = tick && running && conv_ready && shift_free;
    assign conv_next  = running && (ov_mode ? (shift_go && (conv_ch != LAST_CH))
                                            : (shift_fin && (shift_ch != LAST_CH)));
    assign conv_go    = first_go || conv_next;
    assign sweep_end  = shift_fin && (shift_ch == LAST_CH);

    adcseq_conv #(.SET_W(SET_W)) u_conv (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .launch     (conv_go),
        .ack        (shift_go),
        .wait_ticks (wait_q),
        .ready      (conv_ready),
        .cnv        (adc_cnv)
    );

    adcseq_shift #(.DATA_W(DATA_W), .CH_W(CH_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .launch     (shift_go),
        .chan_in    (conv_ch),
        .sdo        (adc_sdo),
        .csn        (adc_csn),
        .free       (shift_free),
        .fin        (shift_fin),
        .cur_chan   (shift_ch),
        .word_valid (out_valid),
        .word_data  (out_data),
        .word_chan  (out_chan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            running    <= 1'b0;
            ov_mode    <= 1'b0;
            wait_q     <= SETTLE_LO;
            conv_ch    <= '0;
            sweep_done <= 1'b0;
        end else begin
            sweep_done <= sweep_end;
            if (accept) begin
                armed   <= 1'b1;
                ov_mode <= overlap_en;
                wait_q  <= settle_eff;
            end
            if (first_go) begin
                armed   <= 1'b0;
                running <= 1'b1;
                conv_ch <= '0;
            end else if (conv_next) begin
                conv_ch <= conv_ch + CH_W'(1);
            end
            if (sweep_end) running <= 1'b0;
        end
    end

    assign mux_sel = conv_ch;
endmodule

// File: rtl/adc_sweep_seq_chk.sv
module adc_sweep_seq_chk #(
    parameter int N_CH   = 18,
    parameter int DATA_W = 16,
    parameter int CH_W   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_sclk,
    input logic              adc_cnv,
    input logic              adc_csn,
    input logic [CH_W-1:0]   mux_sel,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [CH_W-1:0]   out_chan,
    input logic              sweep_done
);
    AST_SCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sclk) |=> adc_sclk); // R1
    AST_SCLK_LOW_TWO: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sclk) |=> !adc_sclk); // R1
    AST_WORD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R2
    AST_MUX_HELD: assert property (@(posedge clk) disable iff (rst)
        (adc_cnv && $past(adc_cnv)) |-> $stable(mux_sel)); // R5
    AST_DONE_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> out_valid); // R6
    AST_DONE_LAST_CHAN: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> (out_chan == CH_W'(N_CH - 1))); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sweep_done |=> !sweep_done); // R6
    AST_CNV_RISE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cnv) |-> $rose(adc_sclk)); // R10
    AST_CNV_FALL_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cnv) |-> $rose(adc_sclk)); // R10
    AST_CSN_FALL_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_csn) |-> $rose(adc_sclk)); // R10
    AST_CSN_RISE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_csn) |-> $rose(adc_sclk)); // R10
endmodule

bind adc_sweep_seq adc_sweep_seq_chk #(
    .N_CH   (N_CH),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adc_sclk   (adc_sclk),
    .adc_cnv    (adc_cnv),
    .adc_csn    (adc_csn),
    .mux_sel    (mux_sel),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_chan   (out_chan),
    .sweep_done (sweep_done)
);

// File: tb/tb_adc_sweep_seq.sv
module tb_adc_sweep_seq;
    localparam int N  = 18;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          overlap_en = 1'b0;
    logic [7:0]    settle_ticks = 8'd25;
    logic          adc_sdo = 1'b0;
    logic          adc_sclk, adc_cnv, adc_csn, out_valid, sweep_done;
    logic [4:0]    mux_sel, out_chan;
    logic [DW-1:0] out_data;

    always #10 clk = ~clk;

    adc_sweep_seq dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .overlap_en   (overlap_en),
        .settle_ticks (settle_ticks),
        .adc_sclk     (adc_sclk),
        .adc_cnv      (adc_cnv),
        .adc_csn      (adc_csn),
        .adc_sdo      (adc_sdo),
        .mux_sel      (mux_sel),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_chan     (out_chan),
        .sweep_done   (sweep_done)
    );

    // ---------------- reference schedule ----------------
    int            edge_no = 0;
    int            rst_edges = 0;
    int            busy_until = -1;
    int            have = 0;
    bit            m_ov = 1'b0;
    int            gm = 0;
    int            cl[N], shl[N], wv[N];
    logic [DW-1:0] xw[N];
    string         scen = "R9";

    function automatic logic [DW-1:0] word_for(input int ch, input int g);
        logic [DW-1:0] w;
        w[15:11] = 5'(ch);
        w[10:0]  = 11'(g * 97 + 5);
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            edge_no = 0;
            rst_edges++;
        end else begin
            edge_no++;
            if (start && edge_no > busy_until) begin
                int w, p, s0;
                w  = (settle_ticks < 8'd2) ? 2 : int'(settle_ticks);
                p  = (w > 16) ? w : 16;
                s0 = (edge_no / 4 + 1) * 4;
                m_ov = overlap_en;
                for (int k = 0; k < N; k++) begin
                    if (!overlap_en) begin
                        cl[k]  = s0 + k * 4 * (w + 16);
                        shl[k] = cl[k] + 4 * w;
                    end else begin
                        cl[k]  = (k == 0) ? s0 : s0 + 4 * (w + (k - 1) * p);
                        shl[k] = s0 + 4 * (w + k * p);
                    end
                    wv[k] = shl[k] + 64;
                    xw[k] = word_for(k, gm + k);
                end
                gm = gm + N;
                busy_until = wv[N-1];
                have = 1;
            end
        end
    end

    // ---------------- ADC stub ----------------
    logic [DW-1:0] fifo[$];
    logic [DW-1:0] cur = '0;
    int            bits_left = 0;
    int            gs = 0;
    logic          sclk_q = 1'b0, cnv_q = 1'b0;

    always @(negedge clk) begin
        if (adc_cnv === 1'b1 && cnv_q !== 1'b1) begin
            fifo.push_back({mux_sel, 11'(gs * 97 + 5)});
            gs++;
        end
        if (adc_sclk === 1'b1 && sclk_q !== 1'b1 && adc_csn === 1'b0) begin
            if (bits_left == 0 && fifo.size() > 0) begin
                cur = fifo.pop_front();
                bits_left = 16;
            end
            if (bits_left > 0) begin
                adc_sdo = cur[bits_left-1];
                bits_left--;
            end
        end
        sclk_q = adc_sclk;
        cnv_q  = adc_cnv;
    end

    // ---------------- per-cycle comparison ----------------
    int checks = 0;
    int bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] edge=%0d act=%0h exp=%0h", tag, scen, edge_no, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            if (rst_edges >= 1) begin
                chk("R9 out_valid", 32'(out_valid), 0);
                chk("R9 sweep_done", 32'(sweep_done), 0);
                chk("R9 adc_cnv", 32'(adc_cnv), 0);
                chk("R9 adc_csn", 32'(adc_csn), 1);
                chk("R9 mux_sel", 32'(mux_sel), 0);
                chk("R1 adc_sclk in reset", 32'(adc_sclk), 1);
            end
        end else begin
            bit ev, ed, ecsn, ecnv;
            int ech;
            ev = 0; ed = 0; ecsn = 1; ecnv = 0; ech = 0;
            if (have != 0) begin
                for (int k = 0; k < N; k++) begin
                    if (wv[k] == edge_no) begin
                        ev = 1;
                        ech = k;
                    end
                    if (edge_no >= shl[k] && edge_no < shl[k] + 64) ecsn = 0;
                    if (edge_no >= cl[k] && edge_no < cl[k] + 4) ecnv = 1;
                end
                ed = (edge_no == wv[N-1]);
            end
            chk("R1 adc_sclk", 32'(adc_sclk), 32'((edge_no % 4) < 2));
            chk(m_ov ? "R4 out_valid timing" : "R3 out_valid timing", 32'(out_valid), 32'(ev));
            chk("R6 sweep_done", 32'(sweep_done), 32'(ed));
            chk("R10 adc_csn window", 32'(adc_csn), 32'(ecsn));
            chk("R10 adc_cnv pulse", 32'(adc_cnv), 32'(ecnv));
            if (ev) begin
                chk("R2 out_data msb-first", 32'(out_data), 32'(xw[ech]));
                chk("R5 out_chan order", 32'(out_chan), 32'(ech));
            end
        end
    end

    // ---------------- stimulus ----------------
    bit wd_hit = 1'b0;

    task automatic sweep(input bit ov, input logic [7:0] w, input string s, input bit again);
        @(negedge clk);
        scen = s;
        overlap_en   = ov;
        settle_ticks = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: inputs changed after acceptance must not alter the sweep
        overlap_en   = ~ov;
        settle_ticks = 8'd3;
        if (again) begin
            // R7: a second request in the middle of the sweep is ignored
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (edge_no <= busy_until + 20) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        sweep(1'b0, 8'd25, "R3 R7 sequential W=25, restart during sweep", 1'b1);
        sweep(1'b1, 8'd25, "R4 overlapped W=25", 1'b0);
        sweep(1'b1, 8'd5,  "R4 overlapped W=5 below shift length", 1'b0);
        sweep(1'b0, 8'd0,  "R8 sequential W=0 clamped to 2", 1'b0);
        sweep(1'b1, 8'd16, "R4 overlapped W=16 equal to shift length", 1'b0);
        sweep(1'b0, 8'd30, "R3 R8 sequential W=30", 1'b0);
        if (!wd_hit) begin
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
        $display("watchdog expired");
        $display("test done: total=%0d bad=%0d", checks + 1, bad + 1);
        $finish;
    end
endmodule